// File: doc/BRIEF.md
# Register-Compare Softcore Processor

This block is a small 32-bit processor core. It fetches fixed 32-bit instruction words from an external 256-word program memory and executes them against 32 general registers. The instruction set follows C operators: addition, bitwise logic, shifts, and comparisons that branch directly on two registers without flags. Jumps and immediate loads take two program words. The second word holds the 32-bit target or constant.

Every instruction takes two clock cycles. In the fetch cycle the core presents `pc` on the program port and latches the returned word. In the execute cycle it presents `pc+1` so that an operand word can be read, does the work and updates `pc`. Both memories are read combinationally. A store drives the data-memory port for one cycle, and a load takes its result from the data port in that same cycle.

Top module: `cc_core`

## Requirements
- R1: While `rst_ni` is low, `pc` is 0 and all 32 registers are 0. The first fetch after release reads address 0, and a register that has not been written reads back as zero.
- R2: The instruction word holds the opcode in bits 31:24 and the register selectors in bits 23:16 (a), 15:8 (b) and 7:0 (c). The low five bits of a selector pick the register, and a store sends register a to `dmem_addr_o`.
- R3: Fetch and execute cycles alternate. In fetch, `imem_addr_o` equals `pc` and no write happens. In execute, `imem_addr_o` equals `pc+1`.
- R4: Opcode 1 loads `pc` with the low 8 bits of the word at `pc+1`.
- R5: Opcodes 2 to 7 compare register a with register b as unsigned values, testing equal, not equal, greater, greater-or-equal, less and less-or-equal in that order. When the test holds, `pc` takes the word at `pc+1`; otherwise `pc` advances by 2.
- R6: Opcode 8 writes the word at `pc+1` into register a and advances `pc` by 2.
- R7: Opcodes 15, 16, 17 and 18 write b AND c, b OR c, b XOR c and b+c (modulo 2^32) into register a. Opcode 14 writes the bitwise inverse of register b. Each advances `pc` by 1.
- R8: Opcode 12 shifts register b left and opcode 13 shifts it right logically. The shift amount is the full value of register c, and an amount of 32 or more gives zero.
- R9: Opcode 11 raises `dmem_we_o` for exactly one execute cycle, with `dmem_wdata_o` equal to register b. No other opcode raises `dmem_we_o`.
- R10: Opcode 10 writes `dmem_rdata_i`, read at the address held in register b, into register a and advances `pc` by 1.
- R11: Opcode 0, opcode 9 and opcodes 19 to 255 advance `pc` by 1 and change no register and no memory.
- R12: `pc` is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Program memory word address |
| imem_rdata_i | input | 32 | Program memory word, combinational read |
| dmem_addr_o | output | 32 | Data memory address |
| dmem_wdata_o | output | 32 | Data memory write data |
| dmem_we_o | output | 1 | Data memory write strobe, one cycle |
| dmem_rdata_i | input | 32 | Data memory read data, combinational |

## Verification
The program pits `0x80000001` against small values, so a signed comparison takes the wrong branch of a jump and shows up as a wrong fetch address. Shift amounts of 31, 32 and 100 catch a shifter that uses only the low five bits: it would return a nonzero result where zero is required. An increment of `0xFFFFFFFF` checks that the sum wraps to zero. Each not-taken branch is followed by a visible counter increment, so a core that skips one word instead of two, or the reverse, leaves a wrong count in memory. Filler opcodes whose selectors name live registers must leave those registers untouched. Zero-filled program space carries `pc` past 255 and back to 0, which checks the wrap.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int INSN_W = 32;
  localparam int FLD_W  = 8;

  typedef enum logic [FLD_W-1:0] {
    OP_NOP   = 8'd0,
    OP_JMP   = 8'd1,
    OP_JEQ   = 8'd2,
    OP_JNE   = 8'd3,
    OP_JGT   = 8'd4,
    OP_JGE   = 8'd5,
    OP_JLT   = 8'd6,
    OP_JLE   = 8'd7,
    OP_LDI   = 8'd8,
    OP_LOAD  = 8'd10,
    OP_STORE = 8'd11,
    OP_SHL   = 8'd12,
    OP_SHR   = 8'd13,
    OP_INV   = 8'd14,
    OP_AND   = 8'd15,
    OP_OR    = 8'd16,
    OP_XOR   = 8'd17,
    OP_ADD   = 8'd18
  } opcode_e;

  // field order is fixed by the encoding
  typedef struct packed {
    logic [FLD_W-1:0] op;
    logic [FLD_W-1:0] fa;
    logic [FLD_W-1:0] fb;
    logic [FLD_W-1:0] fc;
  } insn_t;

  function automatic logic writes_reg(opcode_e op);
    case (op)
      OP_LDI, OP_LOAD, OP_SHL, OP_SHR, OP_INV,
      OP_AND, OP_OR, OP_XOR, OP_ADD: writes_reg = 1'b1;
      default:                       writes_reg = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cc_regfile.sv
module cc_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [IDX_W-1:0]  raddr_b_i,
  input  logic [IDX_W-1:0]  raddr_c_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] rdata_c_o
);
  logic [DATA_W-1:0] regs_q [REG_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < REG_N; i++)
        if (we_i && waddr_i == IDX_W'(i)) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_c_o = regs_q[raddr_c_i];
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  opcode_e           op_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] res_o
);
  logic            sh_big;
  logic [SH_W-1:0] sh_amt;

  // any bit above the index range means a shift of DATA_W or more
  assign sh_big = |c_i[DATA_W-1:SH_W];
  assign sh_amt = c_i[SH_W-1:0];

  always_comb begin
    case (op_i)
      OP_SHL:  res_o = sh_big ? '0 : (b_i << sh_amt);
      OP_SHR:  res_o = sh_big ? '0 : (b_i >> sh_amt);
      OP_INV:  res_o = ~b_i;
      OP_AND:  res_o = b_i & c_i;
      OP_OR:   res_o = b_i | c_i;
      OP_XOR:  res_o = b_i ^ c_i;
      OP_ADD:  res_o = b_i + c_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/cc_nextpc.sv
module cc_nextpc
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input  opcode_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [INSN_W-1:0] opnd_i,
  output logic [PC_W-1:0]   next_pc_o
);
  logic            taken;
  logic [PC_W-1:0] target;
  logic            unused_hi;

  assign target    = opnd_i[PC_W-1:0];
  assign unused_hi = ^opnd_i[INSN_W-1:PC_W];

  always_comb begin
    case (op_i)
      OP_JEQ:  taken = (a_i == b_i);
      OP_JNE:  taken = (a_i != b_i);
      OP_JGT:  taken = (a_i >  b_i);
      OP_JGE:  taken = (a_i >= b_i);
      OP_JLT:  taken = (a_i <  b_i);
      OP_JLE:  taken = (a_i <= b_i);
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_JMP:                   next_pc_o = target;
      OP_JEQ, OP_JNE, OP_JGT,
      OP_JGE, OP_JLT, OP_JLE:   next_pc_o = taken ? target : pc_i + PC_W'(2);
      OP_LDI:                   next_pc_o = pc_i + PC_W'(2);
      default:                  next_pc_o = pc_i + PC_W'(1);
    endcase
  end
endmodule

// File: rtl/cc_core.sv
module cc_core
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8,
  parameter int REG_N  = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [INSN_W-1:0] imem_rdata_i,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  output logic              dmem_we_o,
  input  logic [DATA_W-1:0] dmem_rdata_i
);
  logic              exec_q;
  logic [PC_W-1:0]   pc_q;
  insn_t             ir_q;
  logic [FLD_W-1:0]  op_raw;
  opcode_e           op_w;
  logic [PC_W-1:0]   next_pc;
  logic [DATA_W-1:0] ra_val, rb_val, rc_val, alu_res, wr_data;
  logic              wr_en;
  logic              unused_fld;

  assign op_raw     = ir_q.op;
  assign op_w       = opcode_e'(op_raw);
  assign unused_fld = ^{ir_q.fa[FLD_W-1:IDX_W], ir_q.fb[FLD_W-1:IDX_W], ir_q.fc[FLD_W-1:IDX_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= 1'b0;
      pc_q   <= '0;
      ir_q   <= '0;
    end else if (!exec_q) begin
      ir_q   <= imem_rdata_i;
      exec_q <= 1'b1;
    end else begin
      pc_q   <= next_pc;
      exec_q <= 1'b0;
    end
  end

  // execute cycle exposes the operand word
  assign imem_addr_o = exec_q ? pc_q + PC_W'(1) : pc_q;

  cc_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .waddr_i   (ir_q.fa[IDX_W-1:0]),
    .wdata_i   (wr_data),
    .raddr_a_i (ir_q.fa[IDX_W-1:0]),
    .raddr_b_i (ir_q.fb[IDX_W-1:0]),
    .raddr_c_i (ir_q.fc[IDX_W-1:0]),
    .rdata_a_o (ra_val),
    .rdata_b_o (rb_val),
    .rdata_c_o (rc_val)
  );

  cc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_w),
    .b_i   (rb_val),
    .c_i   (rc_val),
    .res_o (alu_res)
  );

  cc_nextpc #(.DATA_W(DATA_W), .PC_W(PC_W)) u_npc (
    .op_i      (op_w),
    .a_i       (ra_val),
    .b_i       (rb_val),
    .pc_i      (pc_q),
    .opnd_i    (imem_rdata_i),
    .next_pc_o (next_pc)
  );

  assign wr_en = exec_q && writes_reg(op_w);

  always_comb begin
    case (op_w)
      OP_LDI:  wr_data = DATA_W'(imem_rdata_i);
      OP_LOAD: wr_data = dmem_rdata_i;
      default: wr_data = alu_res;
    endcase
  end

  assign dmem_addr_o  = (op_w == OP_STORE) ? ra_val : rb_val;
  assign dmem_wdata_o = rb_val;
  assign dmem_we_o    = exec_q && (op_w == OP_STORE);
endmodule

// File: rtl/cc_core_sva.sv
module cc_core_sva #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [7:0]        op_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [PC_W-1:0]   imem_addr_i,
  input logic [31:0]       opnd_i,
  input logic [DATA_W-1:0] ra_i,
  input logic [DATA_W-1:0] rb_i,
  input logic              we_i
);
  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i);

  a_r9_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (exec_i && op_i == 8'd11));

  a_r4_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 8'd1) |=> imem_addr_i == $past(opnd_i[PC_W-1:0]));

  a_r6_ldi_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 8'd8) |=> imem_addr_i == PC_W'($past(pc_i) + PC_W'(2)));

  a_r5_eq_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 8'd2 && ra_i != rb_i) |=> imem_addr_i == PC_W'($past(pc_i) + PC_W'(2)));

  a_r11_nop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 8'd0) |=> imem_addr_i == PC_W'($past(pc_i) + PC_W'(1)));
endmodule

bind cc_core cc_core_sva #(.DATA_W(DATA_W), .PC_W(PC_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_q),
  .op_i        (op_raw),
  .pc_i        (pc_q),
  .imem_addr_i (imem_addr_o),
  .opnd_i      (imem_rdata_i),
  .ra_i        (ra_val),
  .rb_i        (rb_val),
  .we_i        (dmem_we_o)
);

// File: tb/cc_core_test.sv
`timescale 1ns/1ps
module cc_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] prog [256];
  logic [31:0] dm   [64];
  logic [7:0]  imem_addr;
  logic [31:0] imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  assign imem_rdata = prog[imem_addr];
  assign dmem_rdata = dm[dmem_addr[5:0]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[5:0]] <= dmem_wdata;

  cc_core uut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit          m_exec;
  logic [7:0]  m_pc;
  logic [31:0] m_ir;
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [64];
  string       m_wtag [32];
  string       m_ptag;

  task automatic step();
    if (!m_exec) begin
      chk(imem_addr == m_pc, m_ptag, "fetch address", {24'd0, imem_addr}, {24'd0, m_pc});
      chk(dmem_we == 1'b0, "R3", "write in fetch", {31'd0, dmem_we}, 32'd0);
      m_ir   = prog[m_pc];
      m_exec = 1'b1;
    end else begin
      logic [7:0]  op;
      logic [4:0]  a, b, c;
      logic [31:0] va, vb, vc, opnd;
      logic [7:0]  npc;
      bit          t;
      op = m_ir[31:24]; a = m_ir[20:16]; b = m_ir[12:8]; c = m_ir[4:0];
      va = m_rf[a]; vb = m_rf[b]; vc = m_rf[c];
      opnd = prog[8'(m_pc + 8'd1)];
      chk(imem_addr == 8'(m_pc + 8'd1), "R3", "operand address", {24'd0, imem_addr}, {24'd0, 8'(m_pc + 8'd1)});
      chk(dmem_we == (op == 8'd11), "R9", "write strobe", {31'd0, dmem_we}, {31'd0, op == 8'd11});
      if (op == 8'd11) begin
        chk(dmem_addr == va, "R2", "store address", dmem_addr, va);
        chk(dmem_wdata == vb, m_wtag[b], "stored value", dmem_wdata, vb);
        m_dm[va[5:0]] = vb;
      end
      npc = 8'(m_pc + 8'd1);
      m_ptag = "R11";
      case (op)
        8'd1: begin npc = opnd[7:0]; m_ptag = "R4"; end
        8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7: begin
          case (op)
            8'd2: t = (va == vb);
            8'd3: t = (va != vb);
            8'd4: t = (va > vb);
            8'd5: t = (va >= vb);
            8'd6: t = (va < vb);
            default: t = (va <= vb);
          endcase
          npc = t ? opnd[7:0] : 8'(m_pc + 8'd2);
          m_ptag = "R5";
        end
        8'd8:  begin m_rf[a] = opnd; m_wtag[a] = "R6"; npc = 8'(m_pc + 8'd2); m_ptag = "R6"; end
        8'd10: begin m_rf[a] = m_dm[vb[5:0]]; m_wtag[a] = "R10"; m_ptag = "R10"; end
        8'd11: m_ptag = "R9";
        8'd12: begin m_rf[a] = (vc >= 32) ? 32'd0 : vb << vc[4:0]; m_wtag[a] = "R8"; m_ptag = "R8"; end
        8'd13: begin m_rf[a] = (vc >= 32) ? 32'd0 : vb >> vc[4:0]; m_wtag[a] = "R8"; m_ptag = "R8"; end
        8'd14: begin m_rf[a] = ~vb;     m_wtag[a] = "R7"; m_ptag = "R7"; end
        8'd15: begin m_rf[a] = vb & vc; m_wtag[a] = "R7"; m_ptag = "R7"; end
        8'd16: begin m_rf[a] = vb | vc; m_wtag[a] = "R7"; m_ptag = "R7"; end
        8'd17: begin m_rf[a] = vb ^ vc; m_wtag[a] = "R7"; m_ptag = "R7"; end
        8'd18: begin m_rf[a] = vb + vc; m_wtag[a] = "R7"; m_ptag = "R7"; end
        default: ;
      endcase
      if (m_pc == 8'd255 && npc == 8'd0) m_ptag = "R12";
      m_pc   = npc;
      m_exec = 1'b0;
    end
  endtask

  int ptr;
  function automatic logic [31:0] enc(int op, int a, int b, int c);
    return {op[7:0], a[7:0], b[7:0], c[7:0]};
  endfunction
  task automatic put(input logic [31:0] w);
    prog[ptr] = w;
    ptr++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 32'd0;
    for (int i = 0; i < 64; i++) begin dm[i] = 32'd0; m_dm[i] = 32'd0; end
    for (int i = 0; i < 32; i++) begin m_rf[i] = 32'd0; m_wtag[i] = "R1"; end
    m_exec = 1'b0; m_pc = 8'd0; m_ptag = "R1";
    ptr = 0;
    put(enc(8, 1, 0, 0));  put(32'h8000_0001);
    put(enc(8, 2, 0, 0));  put(32'd4);
    put(enc(8, 3, 0, 0));  put(32'd31);
    put(enc(8, 4, 0, 0));  put(32'd32);
    put(enc(8, 5, 0, 0));  put(32'd100);
    put(enc(8, 6, 0, 0));  put(32'hFFFF_FFFF);
    put(enc(8, 20, 0, 0)); put(32'd0);
    put(enc(8, 21, 0, 0)); put(32'd1);
    put(enc(11, 20, 7, 0)); put(enc(18, 20, 20, 21));  // R1: untouched register
    put(enc(12, 8, 1, 2));  put(enc(12, 9, 1, 3));  put(enc(12, 10, 1, 4));
    put(enc(13, 11, 1, 3)); put(enc(13, 12, 1, 4)); put(enc(13, 13, 1, 5));
    put(enc(15, 14, 1, 6)); put(enc(16, 15, 1, 2)); put(enc(17, 16, 1, 6));
    put(enc(18, 17, 6, 21)); put(enc(14, 18, 1, 0));
    for (int k = 8; k <= 18; k++) begin
      put(enc(11, 20, k, 0)); put(enc(18, 20, 20, 21));
    end
    put(enc(8, 22, 0, 0)); put(32'd2);
    put(enc(10, 19, 22, 0));                            // R10
    put(enc(11, 20, 19, 0)); put(enc(18, 20, 20, 21));
    // R5: every compare, operands ordered both ways and equal
    for (int op = 2; op <= 7; op++) begin
      for (int p = 0; p < 3; p++) begin
        int ra, rb;
        ra = (p == 1) ? 2 : ((p == 2) ? 2 : 1);
        rb = (p == 0) ? 2 : ((p == 1) ? 1 : 2);
        put(enc(op, ra, rb, 0)); put(ptr + 2);
        put(enc(18, 23, 23, 21));
      end
    end
    put(enc(1, 0, 0, 0)); put(ptr + 2);                 // R4
    put(enc(18, 23, 23, 21));
    put(enc(0, 23, 23, 21)); put(enc(9, 23, 23, 21));   // R11
    put(enc(19, 23, 23, 21)); put(enc(255, 23, 6, 21));
    put(enc(11, 20, 23, 0));
    // remaining words stay 0 so pc runs up to 255 and wraps (R12)

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 2500; n++) begin
      step();
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule